// File: doc/BRIEF.md
# PTP Event Frame Classifier and Field Locator

This block sits beside an Ethernet MAC's timestamp logic and watches each frame as a byte stream with start and end markers. While the first bytes of a frame go past, it works out whether the frame carries a precision time protocol message. It follows up to two VLAN tags, then PTP carried directly over Ethernet, over UDP/IPv4 or over UDP/IPv6. For a PTP frame it computes where the correction field and the timestamp field sit, counted in bytes from the first byte of the frame.

For every frame it issues exactly one command. The command says whether the frame is PTP, whether its timestamp should be taken, and at which offsets the fields sit. It also flags when the frame is carried over IPv6, where a second correction must be fixed up, and it carries a fingerprint that lets software pair the frame with its timestamp later. On transmit, the "take timestamp" bit tells the MAC to stamp the frame. On receive, the same bit tells the MAC whether to keep the timestamp it captured or drop it. Only the four event messages are stamped or kept. Follow-up, delay-response, other general messages and non-PTP traffic are not.

Top module: `ptp_frame_classifier`

## Requirements
- R1: After reset `cmd_valid` is low, and bytes that arrive before any start-of-frame marker never produce a command.
- R2: Each frame started by `in_sop` yields exactly one command. `cmd_valid` is high for one cycle, in the cycle after the byte that settles the result. For a PTP frame that byte is the last sequenceId byte (PTP start + 31). Otherwise it is the byte carrying `in_eop`. Idle cycles (`in_valid` low) inside a frame do not change this.
- R3: EtherType 0x88F7 directly after the MAC addresses (or after the tags) marks PTP over Ethernet. `cmd_encap` is 1, the PTP header starts at 14 + 4·tags, and `cmd_ts_ofs` = start + 34 and `cmd_cf_ofs` = start + 8.
- R4: EtherType 0x0800 with first IP byte 0x45, protocol byte (IP + 9) equal to 17, and UDP destination port 319 or 320 marks PTP over IPv4. `cmd_encap` is 2 and the PTP header starts 28 bytes after the IP header starts. Any other first IP byte gives a non-PTP command.
- R5: EtherType 0x86DD with version nibble 6, next-header byte (IP + 6) equal to 17, and UDP destination port 319 or 320 marks PTP over IPv6. `cmd_encap` is 3, the PTP header starts 48 bytes after the IP header starts, and `cmd_cf_extra` is 1. `cmd_cf_extra` is 0 for every other command.
- R6: A type word of 0x8100 or 0x88A8 is a VLAN tag. Each of at most two tags moves the type field 4 bytes later, and `cmd_vlans` reports the count. A third tag makes the frame non-PTP, with `cmd_vlans` = 2.
- R7: `cmd_msg_type` is the low nibble of the first PTP byte; the upper nibble is ignored. `cmd_take_ts` is 1 only for PTP frames with type 0, 1, 2 or 3. It is 0 for Follow_Up (8), Delay_Resp (9) and every other type.
- R8: A non-PTP command has `cmd_is_ptp`, `cmd_take_ts` and `cmd_cf_extra` at 0, and offsets, `cmd_msg_type`, `cmd_fprint` and `cmd_encap` all zero.
- R9: `cmd_fprint` = {message type[3:0], domain byte (PTP + 4), sequenceId (PTP + 30 high, PTP + 31 low)}, 28 bits.
- R10: A UDP destination port other than 319/320, an IP protocol other than 17, or a frame that ends before its last sequenceId byte gives a non-PTP command at `in_eop`.
- R11: An `in_sop` in the middle of a frame abandons that frame without a command and starts parsing afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sop | input | 1 | This byte is the first byte of a frame |
| in_eop | input | 1 | This byte is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_is_ptp | output | 1 | Frame carries a PTP message |
| cmd_take_ts | output | 1 | Stamp (transmit) or keep (receive) the timestamp |
| cmd_cf_extra | output | 1 | IPv6 carriage: additional correction needed |
| cmd_ts_ofs | output | OFS_W | Timestamp field byte offset from frame start |
| cmd_cf_ofs | output | OFS_W | Correction field byte offset from frame start |
| cmd_msg_type | output | 4 | PTP message type |
| cmd_fprint | output | 28 | Frame fingerprint |
| cmd_encap | output | 2 | 0 none, 1 Ethernet, 2 IPv4/UDP, 3 IPv6/UDP |
| cmd_vlans | output | TAG_W | Number of VLAN tags passed |

## Verification
The main function is driven with frames built byte by byte for each carriage: Ethernet, IPv4 and IPv6. Each carriage is sent with zero, one and two tags, mixing both tag identifiers, so every offset sum is checked against a value derived independently. Event and general message types, together with the masked upper nibble, separate the take decision from the PTP decision. Near-miss frames isolate each gate that has to fail: a wrong port, a wrong protocol, a non-standard IP header length, a third tag, a foreign EtherType and a truncated frame. Idle gaps, orphan bytes before any start marker, and a start marker inside an unfinished frame show that the byte position, not the cycle count, drives parsing.

// File: rtl/ptpc_pkg.sv
// Shared types and protocol constants for the PTP frame classifier.
// Assumes byte offsets are counted from the first byte of the frame.
package ptpc_pkg;

    typedef enum logic [1:0] {
        ENC_NONE = 2'd0,
        ENC_ETH  = 2'd1,
        ENC_IP4  = 2'd2,
        ENC_IP6  = 2'd3
    } ptpc_encap_e;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_ETH,
        WK_IP4,
        WK_IP6,
        WK_UDP,
        WK_PTP,
        WK_DROP
    } ptpc_walk_e;

    localparam logic [15:0] TPID_C     = 16'h8100;
    localparam logic [15:0] TPID_S     = 16'h88A8;
    localparam logic [15:0] ETYPE_PTP  = 16'h88F7;
    localparam logic [15:0] ETYPE_IP4  = 16'h0800;
    localparam logic [15:0] ETYPE_IP6  = 16'h86DD;
    localparam logic [15:0] UDP_EVENT  = 16'd319;
    localparam logic [15:0] UDP_GENRL  = 16'd320;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;
    localparam logic [7:0]  IP4_VIHL   = 8'h45;
    localparam logic [3:0]  IP6_VER    = 4'h6;
    localparam logic [3:0]  EVENT_LIM  = 4'd4;

    localparam int ETH_HDR    = 14;
    localparam int TAG_LEN    = 4;
    localparam int IP4_HDR    = 20;
    localparam int IP4_PROTO  = 9;
    localparam int IP6_HDR    = 40;
    localparam int IP6_NXT    = 6;
    localparam int UDP_HDR    = 8;
    localparam int UDP_DPORT  = 2;
    localparam int PTP_DOM    = 4;
    localparam int PTP_CF     = 8;
    localparam int PTP_SEQ    = 30;
    localparam int PTP_TS     = 34;

    localparam int FP_W       = 28;

endpackage

// File: rtl/ptpc_pos_track.sv
// Byte position tracker: gives the index of the byte on the bus this cycle.
// Assumes in_sop marks index 0; the count saturates at the top of OFS_W.
module ptpc_pos_track #(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    output logic [OFS_W-1:0] cur_idx
);
    localparam logic [OFS_W-1:0] IDX_MAX = '1;

    logic [OFS_W-1:0] cnt_q;

    // Index of the present byte: zero on a start marker, else the running count.
    always_comb begin
        cur_idx = in_sop ? '0 : cnt_q;
    end

    // Advance the count on every accepted byte, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
        end
    end
endmodule

// File: rtl/ptpc_hdr_walk.sv
// Header walker: follows VLAN tags, EtherType, IPv4/IPv6 and UDP to find
// where the PTP header begins. Assumes IPv4 without options (first byte 0x45)
// and IPv6 with UDP as the immediate next header.
module ptpc_hdr_walk
    import ptpc_pkg::*;
#(
    parameter int OFS_W    = 8,
    parameter int MAX_TAGS = 2,
    localparam int TAG_W   = $clog2(MAX_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic [OFS_W-1:0] cur_idx,
    output ptpc_walk_e       walk_st,
    output logic [OFS_W-1:0] ptp_base,
    output ptpc_encap_e      encap,
    output logic [TAG_W-1:0] tags_now
);
    localparam logic [OFS_W-1:0] L_ETH   = OFS_W'(ETH_HDR);
    localparam logic [OFS_W-1:0] L_TAG   = OFS_W'(TAG_LEN);
    localparam logic [OFS_W-1:0] L_ONE   = OFS_W'(1);
    localparam logic [OFS_W-1:0] L_TWO   = OFS_W'(2);
    localparam logic [OFS_W-1:0] L_P4    = OFS_W'(IP4_PROTO);
    localparam logic [OFS_W-1:0] L_N6    = OFS_W'(IP6_NXT);
    localparam logic [OFS_W-1:0] L_U4    = OFS_W'(IP4_HDR);
    localparam logic [OFS_W-1:0] L_U6    = OFS_W'(IP6_HDR);
    localparam logic [OFS_W-1:0] L_DPH   = OFS_W'(UDP_DPORT);
    localparam logic [OFS_W-1:0] L_DPL   = OFS_W'(UDP_DPORT + 1);
    localparam logic [OFS_W-1:0] L_UDP   = OFS_W'(UDP_HDR);
    localparam logic [TAG_W-1:0] TAG_MAX = TAG_W'(MAX_TAGS);

    ptpc_walk_e       st_q, st_w, st_d;
    ptpc_encap_e      enc_q, enc_w, enc_d;
    logic [OFS_W-1:0] l2_q, l2_w, l2_d;
    logic [OFS_W-1:0] ub_q, ub_d;
    logic [OFS_W-1:0] base_q, base_w, base_d;
    logic [TAG_W-1:0] tags_q, tags_w, tags_d;
    logic [7:0]       hi_q, hi_d;
    logic [15:0]      word;

    // Decide the next walk state from the present byte and its index.
    always_comb begin
        st_w   = st_q;
        enc_w  = enc_q;
        l2_w   = l2_q;
        base_w = base_q;
        tags_w = tags_q;
        if (in_sop) begin
            st_w   = WK_ETH;
            enc_w  = ENC_NONE;
            l2_w   = L_ETH;
            base_w = '0;
            tags_w = '0;
        end
        st_d   = st_w;
        enc_d  = enc_w;
        l2_d   = l2_w;
        base_d = base_w;
        tags_d = tags_w;
        ub_d   = ub_q;
        hi_d   = hi_q;
        word   = {hi_q, in_data};
        case (st_w)
            WK_ETH: begin
                if (cur_idx == l2_w - L_TWO) begin
                    hi_d = in_data;
                end else if (cur_idx == l2_w - L_ONE) begin
                    if ((word == TPID_C || word == TPID_S) && tags_w < TAG_MAX) begin
                        tags_d = tags_w + 1'b1;
                        l2_d   = l2_w + L_TAG;
                    end else if (word == ETYPE_PTP) begin
                        st_d   = WK_PTP;
                        base_d = l2_w;
                        enc_d  = ENC_ETH;
                    end else if (word == ETYPE_IP4) begin
                        st_d = WK_IP4;
                    end else if (word == ETYPE_IP6) begin
                        st_d = WK_IP6;
                    end else begin
                        st_d = WK_DROP;
                    end
                end
            end
            WK_IP4: begin
                if (cur_idx == l2_w) begin
                    if (in_data != IP4_VIHL) st_d = WK_DROP;
                end else if (cur_idx == l2_w + L_P4) begin
                    if (in_data == PROTO_UDP) begin
                        st_d  = WK_UDP;
                        ub_d  = l2_w + L_U4;
                        enc_d = ENC_IP4;
                    end else begin
                        st_d = WK_DROP;
                    end
                end
            end
            WK_IP6: begin
                if (cur_idx == l2_w) begin
                    if (in_data[7:4] != IP6_VER) st_d = WK_DROP;
                end else if (cur_idx == l2_w + L_N6) begin
                    if (in_data == PROTO_UDP) begin
                        st_d  = WK_UDP;
                        ub_d  = l2_w + L_U6;
                        enc_d = ENC_IP6;
                    end else begin
                        st_d = WK_DROP;
                    end
                end
            end
            WK_UDP: begin
                if (cur_idx == ub_q + L_DPH) begin
                    hi_d = in_data;
                end else if (cur_idx == ub_q + L_DPL) begin
                    if (word == UDP_EVENT || word == UDP_GENRL) begin
                        st_d   = WK_PTP;
                        base_d = ub_q + L_UDP;
                    end else begin
                        st_d = WK_DROP;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    // Hold the walk state between bytes; idle cycles change nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WK_IDLE;
            enc_q  <= ENC_NONE;
            l2_q   <= L_ETH;
            ub_q   <= '0;
            base_q <= '0;
            tags_q <= '0;
            hi_q   <= '0;
        end else if (in_valid) begin
            st_q   <= st_d;
            enc_q  <= enc_d;
            l2_q   <= l2_d;
            ub_q   <= ub_d;
            base_q <= base_d;
            tags_q <= tags_d;
            hi_q   <= hi_d;
        end
    end

    assign walk_st  = st_q;
    assign ptp_base = base_q;
    assign encap    = enc_q;
    assign tags_now = tags_d;
endmodule

// File: rtl/ptpc_ptp_fields.sv
// PTP header field capture: latches message type, domain and the upper
// sequenceId byte, and flags the byte that completes the sequenceId.
// Assumes the walker has reached its PTP state before the header starts.
module ptpc_ptp_fields
    import ptpc_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic [OFS_W-1:0] cur_idx,
    input  ptpc_walk_e       walk_st,
    input  logic [OFS_W-1:0] ptp_base,
    output logic [3:0]       msg_type,
    output logic [7:0]       domain,
    output logic [7:0]       seq_hi,
    output logic             hdr_done
);
    localparam logic [OFS_W-1:0] L_DOM = OFS_W'(PTP_DOM);
    localparam logic [OFS_W-1:0] L_SQH = OFS_W'(PTP_SEQ);
    localparam logic [OFS_W-1:0] L_SQL = OFS_W'(PTP_SEQ + 1);

    logic in_ptp;

    // A byte belongs to a PTP header only inside a frame already classified.
    always_comb begin
        in_ptp   = in_valid && !in_sop && (walk_st == WK_PTP);
        hdr_done = in_ptp && (cur_idx == ptp_base + L_SQL);
    end

    // Capture the header fields as their bytes pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_type <= '0;
            domain   <= '0;
            seq_hi   <= '0;
        end else if (in_ptp) begin
            if (cur_idx == ptp_base)         msg_type <= in_data[3:0];
            if (cur_idx == ptp_base + L_DOM) domain   <= in_data;
            if (cur_idx == ptp_base + L_SQH) seq_hi   <= in_data;
        end
    end
endmodule

// File: rtl/ptpc_cmd_gen.sv
// Command builder: issues one registered command per frame, either when the
// PTP header is complete or at the end marker of any other frame.
// Assumes hdr_done can only be high for a byte of the current frame.
module ptpc_cmd_gen
    import ptpc_pkg::*;
#(
    parameter int OFS_W    = 8,
    parameter int MAX_TAGS = 2,
    localparam int TAG_W   = $clog2(MAX_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    input  logic             hdr_done,
    input  logic [3:0]       msg_type,
    input  logic [7:0]       domain,
    input  logic [7:0]       seq_hi,
    input  logic [OFS_W-1:0] ptp_base,
    input  ptpc_encap_e      encap,
    input  logic [TAG_W-1:0] tags_now,
    output logic             cmd_valid,
    output logic             cmd_is_ptp,
    output logic             cmd_take_ts,
    output logic             cmd_cf_extra,
    output logic [OFS_W-1:0] cmd_ts_ofs,
    output logic [OFS_W-1:0] cmd_cf_ofs,
    output logic [3:0]       cmd_msg_type,
    output logic [FP_W-1:0]  cmd_fprint,
    output logic [1:0]       cmd_encap,
    output logic [TAG_W-1:0] cmd_vlans
);
    localparam logic [OFS_W-1:0] L_TS = OFS_W'(PTP_TS);
    localparam logic [OFS_W-1:0] L_CF = OFS_W'(PTP_CF);

    logic done_q, done_w, fire_ptp, fire_none;

    // A frame may issue at most one command; start markers re-arm it.
    always_comb begin
        done_w    = in_sop ? 1'b0 : done_q;
        fire_ptp  = hdr_done && !done_w;
        fire_none = in_valid && in_eop && !hdr_done && !done_w;
    end

    // Track whether the current frame already issued its command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b1;
        end else if (in_valid) begin
            done_q <= done_w || fire_ptp || in_eop;
        end
    end

    // Register the command fields for the strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid    <= 1'b0;
            cmd_is_ptp   <= 1'b0;
            cmd_take_ts  <= 1'b0;
            cmd_cf_extra <= 1'b0;
            cmd_ts_ofs   <= '0;
            cmd_cf_ofs   <= '0;
            cmd_msg_type <= '0;
            cmd_fprint   <= '0;
            cmd_encap    <= '0;
            cmd_vlans    <= '0;
        end else begin
            cmd_valid <= fire_ptp || fire_none;
            if (fire_ptp) begin
                cmd_is_ptp   <= 1'b1;
                cmd_take_ts  <= (msg_type < EVENT_LIM);
                cmd_cf_extra <= (encap == ENC_IP6);
                cmd_ts_ofs   <= ptp_base + L_TS;
                cmd_cf_ofs   <= ptp_base + L_CF;
                cmd_msg_type <= msg_type;
                cmd_fprint   <= {msg_type, domain, seq_hi, in_data};
                cmd_encap    <= encap;
                cmd_vlans    <= tags_now;
            end else if (fire_none) begin
                cmd_is_ptp   <= 1'b0;
                cmd_take_ts  <= 1'b0;
                cmd_cf_extra <= 1'b0;
                cmd_ts_ofs   <= '0;
                cmd_cf_ofs   <= '0;
                cmd_msg_type <= '0;
                cmd_fprint   <= '0;
                cmd_encap    <= ENC_NONE;
                cmd_vlans    <= tags_now;
            end
        end
    end
endmodule

// File: rtl/ptp_frame_classifier.sv
// PTP frame classifier top: finds PTP messages in an Ethernet byte stream,
// locates their correction and timestamp fields, and issues one command per
// frame with a fingerprint. Assumes one byte per cycle at most, in order.
module ptp_frame_classifier
    import ptpc_pkg::*;
#(
    parameter int OFS_W    = 8,
    parameter int MAX_TAGS = 2,
    localparam int TAG_W   = $clog2(MAX_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    output logic             cmd_valid,
    output logic             cmd_is_ptp,
    output logic             cmd_take_ts,
    output logic             cmd_cf_extra,
    output logic [OFS_W-1:0] cmd_ts_ofs,
    output logic [OFS_W-1:0] cmd_cf_ofs,
    output logic [3:0]       cmd_msg_type,
    output logic [FP_W-1:0]  cmd_fprint,
    output logic [1:0]       cmd_encap,
    output logic [TAG_W-1:0] cmd_vlans
);
    logic [OFS_W-1:0] cur_idx;
    ptpc_walk_e       walk_st;
    logic [OFS_W-1:0] ptp_base;
    ptpc_encap_e      encap;
    logic [TAG_W-1:0] tags_now;
    logic [3:0]       msg_type;
    logic [7:0]       domain;
    logic [7:0]       seq_hi;
    logic             hdr_done;

    ptpc_pos_track #(.OFS_W(OFS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .cur_idx(cur_idx)
    );

    ptpc_hdr_walk #(.OFS_W(OFS_W), .MAX_TAGS(MAX_TAGS)) u_walk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .cur_idx(cur_idx), .walk_st(walk_st),
        .ptp_base(ptp_base), .encap(encap), .tags_now(tags_now)
    );

    ptpc_ptp_fields #(.OFS_W(OFS_W)) u_fields (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .cur_idx(cur_idx), .walk_st(walk_st),
        .ptp_base(ptp_base), .msg_type(msg_type), .domain(domain),
        .seq_hi(seq_hi), .hdr_done(hdr_done)
    );

    ptpc_cmd_gen #(.OFS_W(OFS_W), .MAX_TAGS(MAX_TAGS)) u_cmd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .hdr_done(hdr_done),
        .msg_type(msg_type), .domain(domain), .seq_hi(seq_hi),
        .ptp_base(ptp_base), .encap(encap), .tags_now(tags_now),
        .cmd_valid(cmd_valid), .cmd_is_ptp(cmd_is_ptp),
        .cmd_take_ts(cmd_take_ts), .cmd_cf_extra(cmd_cf_extra),
        .cmd_ts_ofs(cmd_ts_ofs), .cmd_cf_ofs(cmd_cf_ofs),
        .cmd_msg_type(cmd_msg_type), .cmd_fprint(cmd_fprint),
        .cmd_encap(cmd_encap), .cmd_vlans(cmd_vlans)
    );
endmodule

// File: rtl/ptpc_checker.sv
// Property checker for the PTP frame classifier, attached by bind.
// Assumes the port names and parameters of ptp_frame_classifier.
module ptpc_checker #(
    parameter int OFS_W    = 8,
    parameter int MAX_TAGS = 2,
    localparam int TAG_W   = $clog2(MAX_TAGS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             cmd_valid,
    input logic             cmd_is_ptp,
    input logic             cmd_take_ts,
    input logic             cmd_cf_extra,
    input logic [OFS_W-1:0] cmd_ts_ofs,
    input logic [OFS_W-1:0] cmd_cf_ofs,
    input logic [3:0]       cmd_msg_type,
    input logic [27:0]      cmd_fprint,
    input logic [1:0]       cmd_encap,
    input logic [TAG_W-1:0] cmd_vlans
);
    logic [OFS_W-1:0] l2_ts_exp;
    assign l2_ts_exp = OFS_W'(48 + 4 * int'(cmd_vlans));

    p_cmd_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(in_valid));

    p_l2_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_ptp && cmd_encap == 2'd1) |-> (cmd_ts_ofs == l2_ts_exp));

    p_cf_extra_ipv6_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_cf_extra) |-> (cmd_is_ptp && cmd_encap == 2'd3));

    p_tag_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (int'(cmd_vlans) <= MAX_TAGS));

    p_take_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_take_ts) |-> (cmd_is_ptp && cmd_msg_type < 4'd4));

    p_nonptp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_is_ptp) |-> (cmd_ts_ofs == '0 && cmd_cf_ofs == '0 &&
                                        cmd_fprint == '0 && cmd_encap == 2'd0));

    p_fprint_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_ptp) |-> (cmd_fprint[27:24] == cmd_msg_type));
endmodule

bind ptp_frame_classifier ptpc_checker #(.OFS_W(OFS_W), .MAX_TAGS(MAX_TAGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmd_valid(cmd_valid),
    .cmd_is_ptp(cmd_is_ptp), .cmd_take_ts(cmd_take_ts),
    .cmd_cf_extra(cmd_cf_extra), .cmd_ts_ofs(cmd_ts_ofs),
    .cmd_cf_ofs(cmd_cf_ofs), .cmd_msg_type(cmd_msg_type),
    .cmd_fprint(cmd_fprint), .cmd_encap(cmd_encap), .cmd_vlans(cmd_vlans)
);

// File: tb/test_ptp_frame_classifier.sv
module test_ptp_frame_classifier;
    localparam int OFS_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        cmd_valid, cmd_is_ptp, cmd_take_ts, cmd_cf_extra;
    logic [7:0]  cmd_ts_ofs, cmd_cf_ofs;
    logic [3:0]  cmd_msg_type;
    logic [27:0] cmd_fprint;
    logic [1:0]  cmd_encap, cmd_vlans;

    always #10 clk = ~clk;

    ptp_frame_classifier #(.OFS_W(OFS_W), .MAX_TAGS(2)) i_ptp_frame_classifier (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .cmd_valid(cmd_valid),
        .cmd_is_ptp(cmd_is_ptp), .cmd_take_ts(cmd_take_ts),
        .cmd_cf_extra(cmd_cf_extra), .cmd_ts_ofs(cmd_ts_ofs),
        .cmd_cf_ofs(cmd_cf_ofs), .cmd_msg_type(cmd_msg_type),
        .cmd_fprint(cmd_fprint), .cmd_encap(cmd_encap), .cmd_vlans(cmd_vlans)
    );

    // kind: 0 PTP/Ethernet, 1 IPv4, 2 IPv6, 3 foreign EtherType
    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  ntag;
        logic [7:0]  vihl;
        logic [7:0]  proto;
        logic [15:0] port;
        logic [3:0]  mtype;
        logic [7:0]  dom;
        logic [15:0] seq;
        logic        trunc;
        logic        x_ptp;
        logic        x_take;
        logic [7:0]  x_ts;
        logic [1:0]  x_enc;
        logic [1:0]  x_tags;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd0, 8'h45, 8'd17, 16'd319, 4'h0, 8'h03, 16'h1234, 1'b0, 1'b1, 1'b1, 8'd48,  2'd1, 2'd0},
        '{2'd0, 2'd1, 8'h45, 8'd17, 16'd319, 4'h9, 8'h05, 16'h0001, 1'b0, 1'b1, 1'b0, 8'd52,  2'd1, 2'd1},
        '{2'd1, 2'd0, 8'h45, 8'd17, 16'd319, 4'h1, 8'h00, 16'hBEEF, 1'b0, 1'b1, 1'b1, 8'd76,  2'd2, 2'd0},
        '{2'd1, 2'd2, 8'h45, 8'd17, 16'd320, 4'h8, 8'h7F, 16'h8001, 1'b0, 1'b1, 1'b0, 8'd84,  2'd2, 2'd2},
        '{2'd2, 2'd0, 8'h45, 8'd17, 16'd319, 4'h3, 8'h2A, 16'h00FF, 1'b0, 1'b1, 1'b1, 8'd96,  2'd3, 2'd0},
        '{2'd2, 2'd1, 8'h45, 8'd17, 16'd319, 4'h2, 8'h01, 16'hFFFF, 1'b0, 1'b1, 1'b1, 8'd100, 2'd3, 2'd1},
        '{2'd1, 2'd0, 8'h45, 8'd17, 16'd321, 4'h0, 8'h00, 16'h0042, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 2'd0},
        '{2'd1, 2'd0, 8'h46, 8'd17, 16'd319, 4'h0, 8'h00, 16'h0043, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 2'd0},
        '{2'd0, 2'd3, 8'h45, 8'd17, 16'd319, 4'h0, 8'h00, 16'h0044, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 2'd2},
        '{2'd3, 2'd0, 8'h45, 8'd17, 16'd319, 4'h0, 8'h00, 16'h0045, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 2'd0},
        '{2'd0, 2'd0, 8'h45, 8'd17, 16'd319, 4'h0, 8'h00, 16'h0046, 1'b1, 1'b0, 1'b0, 8'd0,   2'd0, 2'd0},
        '{2'd1, 2'd0, 8'h45, 8'd6,  16'd319, 4'h0, 8'h00, 16'h0047, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 2'd0},
        '{2'd0, 2'd0, 8'h45, 8'd17, 16'd319, 4'hB, 8'h10, 16'h5555, 1'b0, 1'b1, 1'b0, 8'd48,  2'd1, 2'd0}
    };

    int n_chk = 0, n_bad = 0;
    logic [7:0] fb [0:159];
    int f_len, f_base;
    int ncmd, cmd_at;
    logic        c_ptp, c_take, c_ext;
    logic [7:0]  c_ts, c_cf;
    logic [3:0]  c_mt;
    logic [27:0] c_fp;
    logic [1:0]  c_enc, c_tags;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(inout int k, input logic [7:0] b);
        fb[k] = b;
        k = k + 1;
    endtask

    // Assemble a frame for one table row into fb.
    task automatic build(input vec_t v);
        int k = 0;
        for (int i = 0; i < 12; i++) put(k, 8'hA0 + 8'(i));
        for (int t = 0; t < int'(v.ntag); t++) begin
            put(k, (t % 2 == 0) ? 8'h81 : 8'h88);
            put(k, (t % 2 == 0) ? 8'h00 : 8'hA8);
            put(k, 8'h00);
            put(k, 8'h10 + 8'(t));
        end
        case (v.kind)
            2'd0: begin put(k, 8'h88); put(k, 8'hF7); end
            2'd1: begin
                put(k, 8'h08); put(k, 8'h00);
                for (int i = 0; i < 20; i++)
                    put(k, (i == 0) ? v.vihl : (i == 9) ? v.proto : 8'h00);
            end
            2'd2: begin
                put(k, 8'h86); put(k, 8'hDD);
                for (int i = 0; i < 40; i++)
                    put(k, (i == 0) ? 8'h60 : (i == 6) ? v.proto : 8'h00);
            end
            default: begin put(k, 8'h08); put(k, 8'h06); end
        endcase
        if (v.kind == 2'd1 || v.kind == 2'd2) begin
            put(k, 8'h01); put(k, 8'h3F);
            put(k, v.port[15:8]); put(k, v.port[7:0]);
            put(k, 8'h00); put(k, 8'h34); put(k, 8'h00); put(k, 8'h00);
        end
        f_base = k;
        for (int i = 0; i < 44; i++) begin
            if (i == 0)       put(k, {4'hA, v.mtype});
            else if (i == 4)  put(k, v.dom);
            else if (i == 30) put(k, v.seq[15:8]);
            else if (i == 31) put(k, v.seq[7:0]);
            else              put(k, 8'(i));
        end
        f_len = v.trunc ? f_base + 20 : k;
    endtask

    // Drive n bytes of fb and record any command seen.
    task automatic send(input int n, input bit gaps, input bit use_sop, input bit use_eop);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
                @(negedge clk);
                if (cmd_valid) begin ncmd++; cmd_at = -1; end
            end
            in_valid = 1'b1;
            in_sop   = use_sop && (i == 0);
            in_eop   = use_eop && (i == n - 1);
            in_data  = fb[i];
            @(negedge clk);
            if (cmd_valid) begin
                ncmd++; cmd_at = i;
                c_ptp = cmd_is_ptp; c_take = cmd_take_ts; c_ext = cmd_cf_extra;
                c_ts = cmd_ts_ofs; c_cf = cmd_cf_ofs; c_mt = cmd_msg_type;
                c_fp = cmd_fprint; c_enc = cmd_encap; c_tags = cmd_vlans;
            end
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (2) begin
            @(negedge clk);
            if (cmd_valid) ncmd++;
        end
    endtask

    task automatic check_row(input vec_t v, input int row);
        string tg;
        tg = (v.kind == 2'd0) ? "R3" : (v.kind == 2'd1) ? "R4" : (v.kind == 2'd2) ? "R5" : "R10";
        chk($sformatf("R2 row%0d command count", row), ncmd, 1);
        chk($sformatf("R2 row%0d command byte", row), cmd_at, v.x_ptp ? f_base + 31 : f_len - 1);
        chk($sformatf("%s row%0d is_ptp", v.x_ptp ? tg : "R10", row), c_ptp, v.x_ptp);
        chk($sformatf("R7 row%0d take_ts", row), c_take, v.x_take);
        chk($sformatf("%s row%0d ts offset", tg, row), c_ts, v.x_ts);
        chk($sformatf("%s row%0d cf offset", tg, row), c_cf, v.x_ptp ? v.x_ts - 26 : 0);
        chk($sformatf("R5 row%0d cf_extra", row), c_ext, v.x_enc == 2'd3);
        chk($sformatf("%s row%0d encap", tg, row), c_enc, v.x_enc);
        chk($sformatf("R6 row%0d vlans", row), c_tags, v.x_tags);
        if (v.x_ptp) begin
            chk($sformatf("R7 row%0d msg type", row), c_mt, v.mtype);
            chk($sformatf("R9 row%0d fingerprint", row), c_fp, {v.mtype, v.dom, v.seq});
        end else begin
            chk($sformatf("R8 row%0d fingerprint zero", row), c_fp, 0);
            chk($sformatf("R8 row%0d msg type zero", row), c_mt, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 cmd_valid after reset", cmd_valid, 0);

        // R1: bytes before any start marker produce nothing
        build(TBL[0]);
        ncmd = 0;
        send(20, 1'b0, 1'b0, 1'b1);
        chk("R1 orphan bytes command count", ncmd, 0);

        // table walk
        for (int r = 0; r < NV; r++) begin
            build(TBL[r]);
            ncmd = 0; cmd_at = -2;
            send(f_len, 1'b0, 1'b1, 1'b1);
            check_row(TBL[r], r);
        end

        // R2: idle gaps inside an IPv6 frame
        build(TBL[4]);
        ncmd = 0; cmd_at = -2;
        send(f_len, 1'b1, 1'b1, 1'b1);
        chk("R2 gapped command count", ncmd, 1);
        chk("R2 gapped command byte", cmd_at, f_base + 31);
        chk("R2 gapped ts offset", c_ts, 96);

        // R11: restart on a start marker inside an unfinished frame
        build(TBL[2]);
        ncmd = 0; cmd_at = -2;
        send(60, 1'b0, 1'b1, 1'b0);
        build(TBL[0]);
        send(f_len, 1'b0, 1'b1, 1'b1);
        chk("R11 restart command count", ncmd, 1);
        chk("R11 restart encap", c_enc, 1);
        chk("R11 restart ts offset", c_ts, 48);
        chk("R11 restart fingerprint", c_fp, {4'h0, 8'h03, 16'h1234});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule